// File: doc/BRIEF.md
# Radix-2 SRT Mantissa Divider

This block divides one normalized unsigned mantissa by another. Each clock it forms one signed quotient digit from {-1, 0, +1}. The digit comes from comparing the doubled partial remainder against plus and minus one half, so no remainder is ever restored. The partial remainder stays in two's complement. Positive and negative digits are shifted into two separate vectors. One cycle after the last iteration, the vectors are subtracted to give a plain binary quotient. If the final remainder is negative, the quotient drops by one unit in the last place and the divisor is added back to the remainder. The block also reports whether the corrected remainder is nonzero, for use as a sticky bit when rounding.

Both operands are MANT_W-bit fractions with the top bit set, which puts them in [1/2, 1). Halving the dividend on entry keeps the remainder's magnitude strictly below the divisor. The block therefore returns the first N = MANT_W + GUARD_W fractional bits of dividend/(2·divisor). Sign handling, exponent arithmetic and result packing belong to the surrounding unit.

Top module: `srt_mant_div`

## Requirements
- R1: While rst_n is low, busy, done, quotient and rem_nonzero all read 0. The reset acts at once. Its release takes effect on the second rising clock edge after rst_n goes high.
- R2: A high start sampled on a rising edge while busy is low begins a division and captures both operands. busy reads 1 from that edge until the edge that raises done. busy reads 0 in the cycle where done is high.
- R3: done is high for exactly one cycle. It rises on the (N+1)th rising edge after the edge that accepted start, where N = MANT_W + GUARD_W.
- R4: With dividend value a and divisor value d taken as unsigned integers, the quotient reported with done equals floor(a·2^(N-1) / d), an N-bit unsigned integer.
- R5: rem_nonzero reported with done is 1 exactly when a·2^(N-1) is not a multiple of d.
- R6: start is ignored while busy is high. The running division finishes on its original schedule, with its original operands.
- R7: Each iteration picks digit +1 when twice the remainder is at least one half, and subtracts the divisor. It picks -1 when twice the remainder is at most minus one half, and adds the divisor. Otherwise it picks 0 and only doubles. Throughout a division, the magnitude of the partial remainder stays strictly below the divisor.
- R8: quotient and rem_nonzero change only on the edge that raises done. They hold their values in every other cycle.
- R9: A start presented in the cycle where done is high is accepted. The new division then runs on the normal schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division when idle |
| dividend | input | MANT_W | Dividend mantissa, top bit set |
| divisor | input | MANT_W | Divisor mantissa, top bit set |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: result valid |
| quotient | output | MANT_W+GUARD_W | Binary quotient bits |
| rem_nonzero | output | 1 | Corrected remainder is nonzero |

## Verification
Some properties are checked by assertions on every cycle:
- Acceptance of start.
- The single-cycle done pulse at its fixed distance from acceptance.
- The bound of the partial remainder below the divisor.
- The holding of the outputs between pulses.

Other behaviour only the bench scenarios can show. These are the numeric correctness of quotient and sticky bit against the floor formula, and the correction path when the last remainder goes negative. They also cover the refusal of a start mid-run, a restart in the done cycle, and a reset that cuts a division short.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } srt_state_e;

  // signed radix-2 digit: pos=1 -> +1, neg=1 -> -1, both 0 -> 0
  typedef struct packed {
    logic pos;
    logic neg;
  } sdigit_t;
endpackage

// File: rtl/srt_digit_sel.sv
module srt_digit_sel
  import srt_pkg::*;
#(
  parameter int RW      = 16,
  parameter int HALF_SH = 12
) (
  input  logic signed [RW-1:0] rem,
  input  logic signed [RW-1:0] dvs,
  output sdigit_t              dig,
  output logic signed [RW-1:0] rem_nxt
);
  localparam logic signed [RW-1:0] HALF =
    {{(RW-HALF_SH-1){1'b0}}, 1'b1, {HALF_SH{1'b0}}};
  localparam logic signed [RW-1:0] NEG_HALF = -HALF;

  logic signed [RW-1:0] two_p;

  always_comb begin
    two_p = rem <<< 1;
    dig   = '0;
    if (two_p >= HALF) begin
      dig.pos = 1'b1;
      rem_nxt = two_p - dvs;
    end else if (two_p <= NEG_HALF) begin
      dig.neg = 1'b1;
      rem_nxt = two_p + dvs;
    end else begin
      rem_nxt = two_p;
    end
  end
endmodule

// File: rtl/srt_digit_accum.sv
module srt_digit_accum
  import srt_pkg::*;
#(
  parameter int N = 14
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  sdigit_t      dig,
  output logic [N-1:0] qpos,
  output logic [N-1:0] qneg
);
  logic [N-1:0] qpos_d, qneg_d;

  always_comb begin
    qpos_d = qpos;
    qneg_d = qneg;
    if (clr) begin
      qpos_d = '0;
      qneg_d = '0;
    end else if (en) begin
      qpos_d = {qpos[N-2:0], dig.pos};
      qneg_d = {qneg[N-2:0], dig.neg};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qpos <= '0;
      qneg <= '0;
    end else if (clr || en) begin
      qpos <= qpos_d;
      qneg <= qneg_d;
    end
  end
endmodule

// File: rtl/srt_fix.sv
module srt_fix #(
  parameter int N  = 14,
  parameter int RW = 16
) (
  input  logic [N-1:0]         qpos,
  input  logic [N-1:0]         qneg,
  input  logic signed [RW-1:0] rem,
  input  logic signed [RW-1:0] dvs,
  output logic [N-1:0]         quot,
  output logic                 sticky
);
  logic [N-1:0]         raw;
  logic signed [RW-1:0] rem_c;

  always_comb begin
    raw = qpos - qneg;
    if (rem[RW-1]) begin
      quot  = raw - N'(1);
      rem_c = rem + dvs;
    end else begin
      quot  = raw;
      rem_c = rem;
    end
    sticky = (rem_c != '0);
  end
endmodule

// File: rtl/srt_mant_div.sv
module srt_mant_div
  import srt_pkg::*;
#(
  parameter int MANT_W  = 12,
  parameter int GUARD_W = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [MANT_W-1:0]          dividend,
  input  logic [MANT_W-1:0]          divisor,
  output logic                       busy,
  output logic                       done,
  output logic [MANT_W+GUARD_W-1:0]  quotient,
  output logic                       rem_nonzero
);
  localparam int ITER_N = MANT_W + GUARD_W;
  localparam int RW     = MANT_W + 4;
  localparam int CNT_W  = $clog2(ITER_N + 1);

  // reset: asserted at once, released after two edges
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  srt_state_e           state_q, state_d;
  logic [CNT_W-1:0]     cnt_q, cnt_d;
  logic signed [RW-1:0] rem_q, rem_d, dvs_q, dvs_d, rem_nxt;
  logic [ITER_N-1:0]    quot_q, quot_d, qpos, qneg, fix_quot;
  logic                 stk_q, stk_d, fix_stk, done_q, done_d;
  logic                 acc_clr, acc_en;
  sdigit_t              dig;

  srt_digit_sel #(.RW(RW), .HALF_SH(MANT_W)) u_sel (
    .rem(rem_q), .dvs(dvs_q), .dig(dig), .rem_nxt(rem_nxt)
  );

  srt_digit_accum #(.N(ITER_N)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .clr(acc_clr), .en(acc_en),
    .dig(dig), .qpos(qpos), .qneg(qneg)
  );

  srt_fix #(.N(ITER_N), .RW(RW)) u_fix (
    .qpos(qpos), .qneg(qneg), .rem(rem_q), .dvs(dvs_q),
    .quot(fix_quot), .sticky(fix_stk)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    rem_d   = rem_q;
    dvs_d   = dvs_q;
    quot_d  = quot_q;
    stk_d   = stk_q;
    done_d  = 1'b0;
    acc_clr = 1'b0;
    acc_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          // remainder starts at dividend/2, divisor scaled to match
          rem_d   = $signed({{(RW-MANT_W){1'b0}}, dividend});
          dvs_d   = $signed({{(RW-MANT_W-1){1'b0}}, divisor, 1'b0});
          cnt_d   = '0;
          acc_clr = 1'b1;
          state_d = ST_ITER;
        end
      end
      ST_ITER: begin
        rem_d  = rem_nxt;
        acc_en = 1'b1;
        cnt_d  = cnt_q + CNT_W'(1);
        if (cnt_q == CNT_W'(ITER_N - 1)) state_d = ST_FIX;
      end
      ST_FIX: begin
        quot_d  = fix_quot;
        stk_d   = fix_stk;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rem_q   <= '0;
      dvs_q   <= '0;
      quot_q  <= '0;
      stk_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rem_q   <= rem_d;
      dvs_q   <= dvs_d;
      quot_q  <= quot_d;
      stk_q   <= stk_d;
      done_q  <= done_d;
    end
  end

  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;
  assign quotient    = quot_q;
  assign rem_nonzero = stk_q;
endmodule

// File: rtl/srt_mant_div_chk.sv
module srt_mant_div_chk #(
  parameter int N  = 14,
  parameter int RW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 busy,
  input logic                 done,
  input logic [N-1:0]         quotient,
  input logic                 rem_nonzero,
  input logic signed [RW-1:0] rem,
  input logic signed [RW-1:0] dvs
);
  localparam int CW = $clog2(N + 2) + 1;

  logic          run_q;
  logic [CW-1:0] age_q;
  logic signed [RW-1:0] rem_abs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      age_q <= '0;
    end else if (start && !busy) begin
      run_q <= 1'b1;
      age_q <= '0;
    end else if (done) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      age_q <= age_q + CW'(1);
    end
  end

  assign rem_abs = rem[RW-1] ? -rem : rem;

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (done == (age_q == CW'(N + 1))));

  assert_done_has_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run_q);

  assert_rem_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rem_abs < dvs));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(rem_nonzero)));
endmodule

bind srt_mant_div srt_mant_div_chk #(.N(ITER_N), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .start(start), .busy(busy), .done(done),
  .quotient(quotient), .rem_nonzero(rem_nonzero), .rem(rem_q), .dvs(dvs_q)
);

// File: tb/srt_mant_div_test.sv
`timescale 1ns/1ps
module srt_mant_div_test;
  localparam int MW = 12;
  localparam int GW = 2;
  localparam int N  = MW + GW;
  localparam int NV = 8;

  // operand pairs {dividend, divisor}; expected values come from R4/R5 formulas
  localparam logic [2*MW-1:0] VEC [NV] = '{
    {12'd2048, 12'd2048},
    {12'd4095, 12'd2048},
    {12'd2048, 12'd4095},
    {12'd3000, 12'd2500},
    {12'd2049, 12'd4093},
    {12'd3333, 12'd3333},
    {12'd2731, 12'd3071},
    {12'd4095, 12'd4095}
  };

  logic          clk, rst_n, start;
  logic [MW-1:0] dividend, divisor;
  logic          busy, done, rem_nonzero;
  logic [N-1:0]  quotient;
  int n_chk, n_fail;

  srt_mant_div #(.MANT_W(MW), .GUARD_W(GW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .busy(busy), .done(done), .quotient(quotient),
    .rem_nonzero(rem_nonzero)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint exp_q(input longint a, input longint d);
    return (a <<< (N - 1)) / d;
  endfunction

  function automatic longint exp_s(input longint a, input longint d);
    return (((a <<< (N - 1)) % d) != 0) ? 1 : 0;
  endfunction

  // pulse start at a negedge, then count negedges until done
  task automatic launch(input logic [MW-1:0] a, input logic [MW-1:0] d);
    start = 1'b1; dividend = a; divisor = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_one(input logic [MW-1:0] a, input logic [MW-1:0] d);
    int cyc;
    launch(a, d);
    chk("R2 busy after start", busy, 1);
    wait_done(cyc);
    chk("R3 latency", cyc, N + 1);
    chk("R2 busy low in done cycle", busy, 0);
    chk("R4 R7 quotient", quotient, exp_q(a, d));
    chk("R5 sticky", rem_nonzero, exp_s(a, d));
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int cyc;
    logic [N-1:0] q_hold;
    n_chk = 0; n_fail = 0;
    start = 1'b0; dividend = '0; divisor = '0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 quotient", quotient, 0);
    chk("R1 sticky", rem_nonzero, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk
    for (int i = 0; i < NV; i++)
      run_one(VEC[i][2*MW-1:MW], VEC[i][MW-1:0]);

    // R8: outputs hold after done
    q_hold = quotient;
    repeat (5) @(negedge clk);
    chk("R8 quotient held", quotient, q_hold);
    chk("R8 done low", done, 0);

    // R6: start while busy ignored
    launch(12'd3000, 12'd2500);
    repeat (2) @(negedge clk);
    start = 1'b1; dividend = 12'd2048; divisor = 12'd4095;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    chk("R6 latency unchanged", cyc, N + 1 - 3);
    chk("R6 quotient of first op", quotient, exp_q(3000, 2500));
    chk("R6 sticky of first op", rem_nonzero, exp_s(3000, 2500));
    @(negedge clk);
    chk("R6 idle after", busy, 0);

    // R9: start accepted in done cycle
    launch(12'd2731, 12'd3071);
    wait_done(cyc);
    chk("R9 first quotient", quotient, exp_q(2731, 3071));
    launch(12'd4095, 12'd2049);
    chk("R9 busy after restart", busy, 1);
    wait_done(cyc);
    chk("R9 latency", cyc, N + 1);
    chk("R9 quotient", quotient, exp_q(4095, 2049));
    chk("R9 sticky", rem_nonzero, exp_s(4095, 2049));

    // R1: reset mid-division
    launch(12'd3000, 12'd2047 + 12'd1);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 busy cleared", busy, 0);
    chk("R1 quotient cleared", quotient, 0);
    chk("R1 sticky cleared", rem_nonzero, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 done stays low", done, 0);
    run_one(12'd2500, 12'd3900);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule